// File: doc/BRIEF.md
# Prescaled Timer with Match Channels

This block is a free-running timer for a peripheral subsystem. A prescale counter divides the peripheral clock, and each time it wraps it advances a wide timer count. A set of compare channels watches the timer count. On a compare hit, each channel can do any mix of these: raise a sticky interrupt flag, send the count back to zero, or halt counting. Each channel also drives one external match output. A two-bit action field sets what a hit does to that output: hold, drive low, drive high or toggle.

Software reaches every register through a small synchronous bus. The bus has an address, a write strobe, write data, and read data that is valid in the same cycle as the address. A control register starts and stops counting, or holds both counters at zero. Interrupt flags are cleared by writing ones, and all flags are merged onto one request line. A compare fires once for each timer value, in the clock where the counter first takes that value. A slow prescale phase therefore never fires the same compare twice.

Top module: `match_timer`

## Requirements
- R1: The prescale count (offset 0x10) rises by one on each enabled clock. In the clock where it has reached or passed the prescale value (offset 0x0C), it returns to 0 and the timer count (offset 0x08) rises by one. With prescale value P, the timer count advances once every P+1 enabled clocks.
- R2: Control register (offset 0x04) bit 0 is the run bit. While it is 0, both counts keep their values.
- R3: While control bit 1 is 1, both counts are forced to 0 at each clock and stay there. Counting resumes once the bit is written back to 0.
- R4: Compare control (offset 0x14) gives channel n the bits 3n+2:3n, in the order interrupt (3n), restart (3n+1), halt (3n+2). With restart set, the count step that follows a hit loads 0 in place of the increment, so the timer count never goes beyond the compare value.
- R5: With halt set, a hit clears control bit 0. Both counts then hold the values they had when the hit occurred.
- R6: A hit on channel n with its interrupt bit set sets bit n of the flag register (offset 0x00). A flag stays set until a write to offset 0x00 carries a 1 in that bit. Writing 0 leaves it unchanged. With the interrupt bit clear, no flag is set.
- R7: The irq output is high exactly when at least one flag is set.
- R8: The output register (offset 0x3C) holds the match output levels in bits 3:0. It holds channel n's action in bits 2n+5:2n+4, with 00 hold, 01 drive low, 10 drive high, 11 toggle. The action applies to bit n at each hit, and match_out mirrors bits 3:0.
- R9: A compare fires only in the clock where the timer count has just taken the value. When the prescale value is 1 or more and the count sits on the value for several clocks, a toggle action still flips the output only once.
- R10: After reset every register reads 0. Compare values are at offsets 0x18, 0x1C, 0x20 and 0x24. Undefined bits read 0 and ignore writes: control bits 31:2, compare control bits 31:12, output register bits 31:12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register byte offset |
| bus_we | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, same cycle |
| irq | output | 1 | OR of all interrupt flags |
| match_out | output | 4 | External match output levels |

## Verification
The counting path is driven through a table of prescale values and run lengths. The run lengths include counts that end mid-phase, counts that end exactly on a wrap, and a divide-by-one setting. Reading both counts afterwards separates an off-by-one in the wrap compare from a wrong advance rate. Compare actions are run one at a time. Restart with two flagged channels checks the bound on the count, the flag set and the write-one clear. Halt is run with a slow prescale, so the stopped count and the cleared run bit show up at the ports. Four channels with different output actions share one compare value under a two-clock prescale phase. This separates the actions from one another and catches a compare that refires while the count is held.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  localparam int OFF_IR  = 'h00;
  localparam int OFF_TCR = 'h04;
  localparam int OFF_TC  = 'h08;
  localparam int OFF_PR  = 'h0C;
  localparam int OFF_PC  = 'h10;
  localparam int OFF_MCR = 'h14;
  localparam int OFF_MR0 = 'h18;
  localparam int OFF_EMR = 'h3C;

  typedef enum logic [1:0] {
    EM_HOLD   = 2'b00,
    EM_LOW    = 2'b01,
    EM_HIGH   = 2'b10,
    EM_TOGGLE = 2'b11
  } em_act_e;

  // per-channel compare control slice, LSB first: interrupt, restart, halt
  typedef struct packed {
    logic halt;
    logic restart;
    logic intr;
  } ch_ctrl_t;

  function automatic int mr_off(input int ch);
    return OFF_MR0 + 4 * ch;
  endfunction

  function automatic logic em_next(input em_act_e act, input logic cur);
    case (act)
      EM_LOW:    return 1'b0;
      EM_HIGH:   return 1'b1;
      EM_TOGGLE: return ~cur;
      default:   return cur;
    endcase
  endfunction

  function automatic logic wrap_due(input logic [31:0] pc, input logic [31:0] pr);
    return pc >= pr;
  endfunction

endpackage

// File: rtl/tmr_prescale_core.sv
module tmr_prescale_core #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          clr,
  input  logic [CW-1:0] pr,
  input  logic          match_rst,
  output logic [CW-1:0] tc,
  output logic [CW-1:0] pc,
  output logic          tick,
  output logic          tc_fresh
);
  logic rst_pend_q;
  logic restart;

  assign tick    = run && tmr_pkg::wrap_due(32'(pc), 32'(pr));
  assign restart = match_rst || rst_pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tc         <= '0;
      pc         <= '0;
      tc_fresh   <= 1'b0;
      rst_pend_q <= 1'b0;
    end else if (clr) begin
      tc         <= '0;
      pc         <= '0;
      tc_fresh   <= 1'b0;
      rst_pend_q <= 1'b0;
    end else if (tick) begin
      pc         <= '0;
      tc         <= restart ? '0 : tc + 1'b1;
      tc_fresh   <= 1'b1;
      rst_pend_q <= 1'b0;
    end else begin
      if (run) pc <= pc + 1'b1;
      tc_fresh   <= 1'b0;
      rst_pend_q <= restart;
    end
  end
endmodule

// File: rtl/tmr_match_ch.sv
module tmr_match_ch #(
  parameter int CW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CW-1:0]    tc,
  input  logic             tc_fresh,
  input  logic [CW-1:0]    mr,
  input  tmr_pkg::ch_ctrl_t ctrl,
  input  logic [1:0]       act,
  input  logic             em_wr,
  input  logic             em_wval,
  output logic             hit,
  output logic             rst_req,
  output logic             stop_req,
  output logic             em_bit
);
  logic em_base;

  assign hit      = tc_fresh && (tc == mr);
  assign rst_req  = hit && ctrl.restart;
  assign stop_req = hit && ctrl.halt;
  assign em_base  = em_wr ? em_wval : em_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) em_bit <= 1'b0;
    else        em_bit <= hit ? tmr_pkg::em_next(tmr_pkg::em_act_e'(act), em_base) : em_base;
  end
endmodule

// File: rtl/match_timer.sv
module match_timer #(
  parameter int CW  = 32,
  parameter int NCH = 4,
  parameter int AW  = 8,
  parameter int DW  = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq,
  output logic [NCH-1:0] match_out
);
  import tmr_pkg::*;

  localparam int MCRW = 3 * NCH;
  localparam int EMAW = 2 * NCH;

  logic            tcr_en, tcr_rst;
  logic [CW-1:0]   pr_q;
  logic [MCRW-1:0] mcr_q;
  logic [CW-1:0]   mr_q [NCH];
  logic [EMAW-1:0] ema_q;
  logic [NCH-1:0]  flag_q;

  logic [CW-1:0]   tc_q, pc_q;
  logic            tick, tc_fresh;
  logic [NCH-1:0]  match_hit, rst_req, stop_req, irq_set, irq_en;
  logic            stop_hit, run;

  logic wr_ir, wr_tcr, wr_pr, wr_mcr, wr_emr;
  assign wr_ir  = bus_we && (bus_addr == AW'(OFF_IR));
  assign wr_tcr = bus_we && (bus_addr == AW'(OFF_TCR));
  assign wr_pr  = bus_we && (bus_addr == AW'(OFF_PR));
  assign wr_mcr = bus_we && (bus_addr == AW'(OFF_MCR));
  assign wr_emr = bus_we && (bus_addr == AW'(OFF_EMR));

  assign stop_hit = |stop_req;
  assign run      = tcr_en && !tcr_rst && !stop_hit;
  assign irq_set  = match_hit & irq_en;

  tmr_prescale_core #(.CW(CW)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .clr       (tcr_rst),
    .pr        (pr_q),
    .match_rst (|rst_req),
    .tc        (tc_q),
    .pc        (pc_q),
    .tick      (tick),
    .tc_fresh  (tc_fresh)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    ch_ctrl_t ctrl;
    assign ctrl      = ch_ctrl_t'(mcr_q[3*i +: 3]);
    assign irq_en[i] = ctrl.intr;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mr_q[i] <= '0;
      else if (bus_we && bus_addr == AW'(mr_off(i))) mr_q[i] <= bus_wdata[CW-1:0];
    end

    tmr_match_ch #(.CW(CW)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .tc       (tc_q),
      .tc_fresh (tc_fresh),
      .mr       (mr_q[i]),
      .ctrl     (ctrl),
      .act      (ema_q[2*i +: 2]),
      .em_wr    (wr_emr),
      .em_wval  (bus_wdata[i]),
      .hit      (match_hit[i]),
      .rst_req  (rst_req[i]),
      .stop_req (stop_req[i]),
      .em_bit   (match_out[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcr_en  <= 1'b0;
      tcr_rst <= 1'b0;
      pr_q    <= '0;
      mcr_q   <= '0;
      ema_q   <= '0;
      flag_q  <= '0;
    end else begin
      if (wr_tcr) begin
        tcr_en  <= bus_wdata[0];
        tcr_rst <= bus_wdata[1];
      end
      if (stop_hit) tcr_en <= 1'b0;
      if (wr_pr)  pr_q  <= bus_wdata[CW-1:0];
      if (wr_mcr) mcr_q <= bus_wdata[MCRW-1:0];
      if (wr_emr) ema_q <= bus_wdata[NCH +: EMAW];
      flag_q <= (flag_q & ~(wr_ir ? bus_wdata[NCH-1:0] : '0)) | irq_set;
    end
  end

  assign irq = |flag_q;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      AW'(OFF_IR):  bus_rdata = DW'(flag_q);
      AW'(OFF_TCR): bus_rdata = DW'({tcr_rst, tcr_en});
      AW'(OFF_TC):  bus_rdata = DW'(tc_q);
      AW'(OFF_PR):  bus_rdata = DW'(pr_q);
      AW'(OFF_PC):  bus_rdata = DW'(pc_q);
      AW'(OFF_MCR): bus_rdata = DW'(mcr_q);
      AW'(OFF_EMR): bus_rdata = DW'({ema_q, match_out});
      default:      bus_rdata = '0;
    endcase
    for (int i = 0; i < NCH; i++) begin
      if (bus_addr == AW'(mr_off(i))) bus_rdata = DW'(mr_q[i]);
    end
  end
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk #(
  parameter int CW  = 32,
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           tcr_en,
  input logic           tcr_rst,
  input logic [CW-1:0]  tc,
  input logic [CW-1:0]  pc,
  input logic           tick,
  input logic           stop_hit,
  input logic [NCH-1:0] flags,
  input logic           ir_wr,
  input logic [NCH-1:0] match_hit
);
  // R1: a wrap step advances the timer count by one or restarts it
  a_r1_tick_step: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (tc == CW'($past(tc) + 1'b1) || tc == '0));

  // R1: between wraps the prescale count climbs by one
  a_r1_pc_climb: assert property (@(posedge clk) disable iff (!rst_n)
    (tcr_en && !tcr_rst && !stop_hit && !tick) |=> (pc == CW'($past(pc) + 1'b1)));

  // R2: run bit low keeps both counts
  a_r2_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (!tcr_en && !tcr_rst) |=> ($stable(tc) && $stable(pc)));

  // R3: counter reset bit forces zeros
  a_r3_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
    tcr_rst |=> (tc == '0 && pc == '0));

  // R5: halt clears the run bit and holds the count
  a_r5_halt: assert property (@(posedge clk) disable iff (!rst_n)
    stop_hit |=> (!tcr_en && $stable(tc)));

  // R6: without a flag-register write no flag drops
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !ir_wr |=> ((flags & $past(flags)) == $past(flags)));

  // R9: a hit without a new count value is never followed by another
  a_r9_single: assert property (@(posedge clk) disable iff (!rst_n)
    ((|match_hit) && !tick) |=> (match_hit == '0));
endmodule

bind match_timer tmr_chk #(.CW(CW), .NCH(NCH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tcr_en    (tcr_en),
  .tcr_rst   (tcr_rst),
  .tc        (tc_q),
  .pc        (pc_q),
  .tick      (tick),
  .stop_hit  (stop_hit),
  .flags     (flag_q),
  .ir_wr     (wr_ir),
  .match_hit (match_hit)
);

// File: tb/match_timer_tb.sv
module match_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;
  logic [3:0]  match_out;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  match_timer u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .match_out(match_out)
  );

  localparam logic [7:0] A_IR = 8'h00, A_TCR = 8'h04, A_TC = 8'h08, A_PR = 8'h0C,
                         A_PC = 8'h10, A_MCR = 8'h14, A_MR0 = 8'h18, A_MR1 = 8'h1C,
                         A_MR2 = 8'h20, A_MR3 = 8'h24, A_EMR = 8'h3C;

  typedef struct packed {
    logic [31:0] pr;
    logic [15:0] n;
    logic [31:0] exp_tc;
    logic [31:0] exp_pc;
  } vec_t;

  // enabled clocks n with prescale value pr -> tc = n/(pr+1), pc = n%(pr+1)
  localparam vec_t VEC [6] = '{
    '{32'd0, 16'd10, 32'd10, 32'd0},
    '{32'd1, 16'd10, 32'd5,  32'd0},
    '{32'd2, 16'd11, 32'd3,  32'd2},
    '{32'd4, 16'd23, 32'd4,  32'd3},
    '{32'd9, 16'd50, 32'd5,  32'd0},
    '{32'd3, 16'd3,  32'd0,  32'd3}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk);
    #1 bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    #1 d = bus_rdata;
  endtask

  task automatic clear_counts();
    wr(A_TCR, 32'h2);
    wr(A_TCR, 32'h0);
  endtask

  // run exactly n enabled clocks (n >= 1), then stop
  task automatic run_for(input int n);
    wr(A_TCR, 32'h1);
    repeat (n - 1) @(posedge clk);
    wr(A_TCR, 32'h0);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, v2;
    int max_tc;
    bit saw_top;

    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R10: reset values
    rd(A_IR, v);  check("R10 flags reset", v, 0);
    rd(A_TCR, v); check("R10 control reset", v, 0);
    rd(A_TC, v);  check("R10 tc reset", v, 0);
    rd(A_PR, v);  check("R10 pr reset", v, 0);
    rd(A_PC, v);  check("R10 pc reset", v, 0);
    rd(A_MCR, v); check("R10 mcr reset", v, 0);
    rd(A_MR3, v); check("R10 mr3 reset", v, 0);
    rd(A_EMR, v); check("R10 emr reset", v, 0);
    check("R7 irq reset", {31'b0, irq}, 0);
    check("R8 match_out reset", {28'b0, match_out}, 0);

    // R1: prescale table
    for (int i = 0; i < 6; i++) begin
      wr(A_PR, VEC[i].pr);
      clear_counts();
      run_for(int'(VEC[i].n));
      rd(A_TC, v); check("R1 table tc", v, VEC[i].exp_tc);
      rd(A_PC, v); check("R1 table pc", v, VEC[i].exp_pc);
    end

    // R3: hold in reset, then resume
    wr(A_PR, 32'd0);
    wr(A_TCR, 32'h3);
    repeat (10) @(posedge clk);
    rd(A_TC, v); check("R3 tc held zero", v, 0);
    rd(A_PC, v); check("R3 pc held zero", v, 0);
    wr(A_TCR, 32'h1);
    repeat (4) @(posedge clk);
    rd(A_TC, v); check("R3 counting resumes", v, 4);

    // R2: freeze
    wr(A_TCR, 32'h0);
    rd(A_TC, v);
    repeat (6) @(posedge clk);
    rd(A_TC, v2); check("R2 tc frozen", v2, v);

    // R4/R6/R7: restart on ch0 (MR0=3, intr+restart), intr on ch2 (MR2=1)
    wr(A_MR0, 32'd3);
    wr(A_MR2, 32'd1);
    wr(A_MCR, 32'h43);
    clear_counts();
    wr(A_TCR, 32'h1);
    max_tc = 0; saw_top = 0;
    for (int k = 0; k < 20; k++) begin
      rd(A_TC, v);
      if (int'(v) > max_tc) max_tc = int'(v);
      if (v == 3) saw_top = 1;
    end
    check("R4 tc bounded by compare", 32'(max_tc), 3);
    check("R4 tc reaches compare", {31'b0, saw_top}, 1);
    wr(A_TCR, 32'h0);
    repeat (3) @(posedge clk);
    rd(A_IR, v); check("R6 flags set", v, 32'h5);
    check("R7 irq high", {31'b0, irq}, 1);
    wr(A_IR, 32'h0);
    rd(A_IR, v); check("R6 write zero no effect", v, 32'h5);
    wr(A_IR, 32'h1);
    rd(A_IR, v); check("R6 clear bit0", v, 32'h4);
    check("R7 irq with one flag", {31'b0, irq}, 1);
    wr(A_IR, 32'h4);
    rd(A_IR, v); check("R6 clear bit2", v, 32'h0);
    check("R7 irq low", {31'b0, irq}, 0);

    // R5: halt on ch1 at 6 with PR=1
    wr(A_MCR, 32'h20);
    wr(A_MR1, 32'd6);
    wr(A_PR, 32'd1);
    clear_counts();
    wr(A_TCR, 32'h1);
    repeat (30) @(posedge clk);
    rd(A_TCR, v); check("R5 run bit cleared", v, 0);
    rd(A_TC, v);  check("R5 tc held at compare", v, 6);
    rd(A_PC, v);  check("R5 pc held", v, 0);
    rd(A_IR, v);  check("R6 no flag without intr bit", v, 0);

    // R8/R9: output actions, all compares at 2, PR=1
    wr(A_MCR, 32'h0);
    wr(A_MR0, 32'd2); wr(A_MR1, 32'd2); wr(A_MR2, 32'd2); wr(A_MR3, 32'd2);
    wr(A_EMR, 32'h1BC);
    rd(A_EMR, v); check("R8 emr readback", v, 32'h1BC);
    check("R8 levels written", {28'b0, match_out}, 32'hC);
    clear_counts();
    run_for(12);
    rd(A_TC, v); check("R1 tc after action run", v, 6);
    check("R8 R9 actions applied once", {28'b0, match_out}, 32'hB);
    clear_counts();
    run_for(12);
    check("R9 toggle back", {28'b0, match_out}, 32'hA);
    rd(A_IR, v); check("R6 no flag from output actions", v, 0);

    // R10: reserved bits
    wr(A_TCR, 32'hFFFF_FFFC);
    rd(A_TCR, v); check("R10 control reserved", v, 0);
    wr(A_MCR, 32'hFFFF_F000);
    rd(A_MCR, v); check("R10 mcr reserved", v, 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule